// File: doc/BRIEF.md
# SECDED Memory Word Guard with Correction Log

This block protects each 64-bit memory data word with eight check bits, so the stored word is 72 bits wide and the overhead is 12.5%. On the write path it produces the check bits from the data, with no clock delay. On the read path it checks each returned 72-bit word and repairs any single flipped bit. It flags any two flipped bits as uncorrectable. The checked result leaves the block one clock after the word arrives.

Every repaired or uncorrectable read is entered into a small event log together with the address of the access. Software reads the log newest-first through an index port. A saturating counter tallies repairs. Once the tally reaches a programmable threshold, the block raises an alert that asks for the memory module to be scheduled for replacement. Uncorrectable words are passed on exactly as received, and their error flag sits on the same output beat.

Top module: `ecc_guard`

## Requirements
- R1: `wr_chk` follows `wr_data` combinationally. Hamming positions 1 to 71 are used. Data bit i sits at the (i+1)-th position that is 3 or more and not a power of two. `wr_chk[j]`, for j in 0..6, is the XOR of the data bits whose position has bit j set. `wr_chk[7]` makes the XOR of all 72 bits of {`wr_chk`, `wr_data`} zero. The stored word is `rd_code` = {check[7:0], data[63:0]}.
- R2: A word read with `rd_valid` high appears one clock later, with `out_valid` high. A clean word comes out unchanged, with `out_corrected` and `out_fatal` low.
- R3: A word with one flipped data bit comes out repaired, with `out_corrected` high and `out_fatal` low.
- R4: A word whose only flipped bit is one of the check bits (`rd_code[71:64]`) comes out with its data unchanged and `out_corrected` high.
- R5: A word with two flipped bits raises `out_fatal` on its output beat, with `out_corrected` low. `out_data` then equals the received `rd_code[63:0]` unmodified. An odd-parity word whose syndrome names no existing position is treated the same way.
- R6: Each repaired or uncorrectable read is logged in the clock edge that produces its output. The entry holds the read address and a kind bit (`log_fatal` = 1 for uncorrectable). `log_idx` = 0 reads the newest entry and higher indices read older ones. Clean reads are not logged.
- R7: The log holds the last 8 events. `log_count` saturates at 8. `log_overflow` is sticky and is set by any event that overwrites an entry. A `log_clear` pulse empties the log and clears the overflow flag. An index at or past `log_count` reads address 0 and kind 0.
- R8: `corr_count` counts repaired reads only, not uncorrectable ones, and it saturates at its maximum value instead of wrapping.
- R9: `alert` is high while `alert_threshold` is nonzero and `corr_count` is at least `alert_threshold`. A threshold of zero keeps `alert` low.
- R10: `corr_clear` zeroes `corr_count` at the next edge and wins over a repair in the same cycle.
- R11: After reset, the output flags are low, the log is empty with no overflow, and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 64 | Data word being written |
| wr_chk | output | 8 | Check bits for `wr_data` |
| rd_valid | input | 1 | Read word present this cycle |
| rd_addr | input | ADDR_W | Address of the read |
| rd_code | input | 72 | Stored word {check, data} returned from memory |
| out_valid | output | 1 | Checked word valid |
| out_data | output | 64 | Repaired or passed-through data |
| out_corrected | output | 1 | Single-bit error repaired on this beat |
| out_fatal | output | 1 | Uncorrectable error on this beat |
| log_idx | input | log2(LOG_DEPTH) | Log entry to read, 0 = newest |
| log_addr | output | ADDR_W | Address of the selected log entry |
| log_fatal | output | 1 | Selected entry was uncorrectable |
| log_count | output | log2(LOG_DEPTH+1) | Entries held |
| log_overflow | output | 1 | Sticky: an entry was overwritten |
| log_clear | input | 1 | Empty the log and clear overflow |
| alert_threshold | input | CNT_W | Repair count that raises the alert, 0 = off |
| corr_clear | input | 1 | Zero the repair counter |
| corr_count | output | CNT_W | Saturating repair count |
| alert | output | 1 | Module replacement alert |

## Verification
The bench builds the block with ADDR_W = 16, LOG_DEPTH = 8 and CNT_W = 4. The narrow counter saturates after 15 repairs, so the saturation and alert threshold cases come within a few dozen reads. The eight-entry log wraps and sets its overflow flag after nine events. Random words with injected faults in data bits, in check bits including the overall parity bit, and in random bit pairs then run against a model that encodes words through its own Hamming layout.

// File: rtl/ecc_guard_pkg.sv
package ecc_guard_pkg;
  localparam int DATA_W = 64;
  localparam int HAM_W  = 7;
  localparam int CHK_W  = HAM_W + 1;
  localparam int CODE_W = DATA_W + CHK_W;
  localparam int POS_LIM = 1 << HAM_W;

  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_FIX_DATA = 2'd1,
    EV_FIX_CHK  = 2'd2,
    EV_FATAL    = 2'd3
  } ev_kind_e;

  // Hamming position occupied by data bit idx
  function automatic logic [HAM_W-1:0] ham_pos(input int idx);
    logic [HAM_W-1:0] r;
    int n;
    r = '0;
    n = 0;
    for (int p = 3; p < POS_LIM; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == idx) r = HAM_W'(p);
        n++;
      end
    end
    return r;
  endfunction

  // Data bits covered by Hamming check bit j
  function automatic logic [DATA_W-1:0] cover_mask(input int j);
    logic [DATA_W-1:0] m;
    int n;
    m = '0;
    n = 0;
    for (int p = 3; p < POS_LIM; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n < DATA_W && ((p >> j) & 1) == 1) m[n] = 1'b1;
        n++;
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_parity_tree.sv
module ecc_parity_tree
  import ecc_guard_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [HAM_W-1:0]  ham
);
  for (genvar j = 0; j < HAM_W; j++) begin : g_bit
    localparam logic [DATA_W-1:0] MASK = cover_mask(j);
    assign ham[j] = ^(data & MASK);
  end
endmodule

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_guard_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  logic [HAM_W-1:0] ham;

  ecc_parity_tree u_tree (
    .data (data),
    .ham  (ham)
  );

  assign chk = {(^data) ^ (^ham), ham};
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_guard_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] fixed,
  output logic [DATA_W-1:0] flip,
  output ev_kind_e          kind
);
  logic [DATA_W-1:0] raw;
  logic [HAM_W-1:0]  ham_calc;
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic              syn_pow2;
  logic              hit;

  assign raw = code[DATA_W-1:0];

  ecc_parity_tree u_tree (
    .data (raw),
    .ham  (ham_calc)
  );

  assign syn      = ham_calc ^ code[DATA_W +: HAM_W];
  assign odd      = ^code;
  assign syn_pow2 = (syn & (syn - HAM_W'(1))) == '0;

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam logic [HAM_W-1:0] POS = ham_pos(i);
    assign flip[i] = odd && (syn == POS);
  end

  assign hit   = |flip;
  assign fixed = raw ^ flip;

  always_comb begin
    if (!odd && syn == '0)   kind = EV_NONE;
    else if (!odd)           kind = EV_FATAL;
    else if (hit)            kind = EV_FIX_DATA;
    else if (syn_pow2)       kind = EV_FIX_CHK;
    else                     kind = EV_FATAL;
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       wr_fatal,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic                       clr,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [ADDR_W-1:0]          rd_addr,
  output logic                       rd_fatal,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       overflow
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic [DEPTH-1:0]             fatal_q;
  logic [PTR_W-1:0]             wp;
  logic [PTR_W-1:0]             slot;
  logic                         in_range;
  logic                         full;

  assign full     = (count == FULL);
  assign slot     = wp - PTR_W'(1) - rd_idx;
  assign in_range = CNT_W'(rd_idx) < count;
  assign rd_addr  = in_range ? addr_q[slot] : '0;
  assign rd_fatal = in_range && fatal_q[slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      fatal_q  <= '0;
      wp       <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (clr) begin
      wp       <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (wr_en) begin
      addr_q[wp]  <= wr_addr;
      fatal_q[wp] <= wr_fatal;
      wp          <= wp + PTR_W'(1);
      if (full) overflow <= 1'b1;
      else      count    <= count + CNT_W'(1);
    end
  end

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);
  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !clr) |=> (overflow && count == FULL));
  // R7
  log_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !overflow));
endmodule

// File: rtl/ecc_corr_counter.sv
module ecc_corr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt,
  output logic             alert
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (clr)                  cnt <= '0;
    else if (inc && cnt != CMAX)   cnt <= cnt + CNT_W'(1);
  end

  assign alert = (thr != '0) && (cnt >= thr);

  // R8
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CMAX && !clr) |=> cnt == CMAX);
  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));
  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
endmodule

// File: rtl/ecc_guard.sv
module ecc_guard
  import ecc_guard_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LOG_DEPTH = 8,
  parameter int CNT_W     = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [63:0]                    wr_data,
  output logic [7:0]                     wr_chk,
  input  logic                           rd_valid,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic [71:0]                    rd_code,
  output logic                           out_valid,
  output logic [63:0]                    out_data,
  output logic                           out_corrected,
  output logic                           out_fatal,
  input  logic [$clog2(LOG_DEPTH)-1:0]   log_idx,
  output logic [ADDR_W-1:0]              log_addr,
  output logic                           log_fatal,
  output logic [$clog2(LOG_DEPTH+1)-1:0] log_count,
  output logic                           log_overflow,
  input  logic                           log_clear,
  input  logic [CNT_W-1:0]               alert_threshold,
  input  logic                           corr_clear,
  output logic [CNT_W-1:0]               corr_count,
  output logic                           alert
);
  logic [DATA_W-1:0] dec_fixed;
  logic [DATA_W-1:0] dec_flip;
  ev_kind_e          dec_kind;
  logic              ev_fix;
  logic              ev_fatal;

  ecc_encoder u_enc (
    .data (wr_data),
    .chk  (wr_chk)
  );

  ecc_decoder u_dec (
    .code  (rd_code),
    .fixed (dec_fixed),
    .flip  (dec_flip),
    .kind  (dec_kind)
  );

  assign ev_fix   = rd_valid && (dec_kind == EV_FIX_DATA || dec_kind == EV_FIX_CHK);
  assign ev_fatal = rd_valid && (dec_kind == EV_FATAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data      <= '0;
      out_corrected <= 1'b0;
      out_fatal     <= 1'b0;
    end else begin
      out_valid     <= rd_valid;
      out_corrected <= ev_fix;
      out_fatal     <= ev_fatal;
      if (rd_valid) out_data <= dec_fixed;
    end
  end

  ecc_err_log #(
    .ADDR_W (ADDR_W),
    .DEPTH  (LOG_DEPTH)
  ) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ev_fix || ev_fatal),
    .wr_fatal (ev_fatal),
    .wr_addr  (rd_addr),
    .clr      (log_clear),
    .rd_idx   (log_idx),
    .rd_addr  (log_addr),
    .rd_fatal (log_fatal),
    .count    (log_count),
    .overflow (log_overflow)
  );

  ecc_corr_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (ev_fix),
    .clr   (corr_clear),
    .thr   (alert_threshold),
    .cnt   (corr_count),
    .alert (alert)
  );

  // R3
  onehot_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $onehot0(dec_flip));
  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_corrected && out_fatal));
  // R2
  flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_corrected || out_fatal) |-> out_valid);
  // R5
  fatal_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_fatal |-> out_data == $past(rd_code[63:0]));
  // R3
  fix_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_corrected |-> $countones(out_data ^ $past(rd_code[63:0])) <= 1);
endmodule

// File: tb/ecc_guard_bench.sv
module ecc_guard_bench;
  localparam int AW = 16;
  localparam int LD = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [63:0]   wr_data = '0;
  logic [7:0]    wr_chk;
  logic          rd_valid = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [71:0]   rd_code = '0;
  logic          out_valid;
  logic [63:0]   out_data;
  logic          out_corrected;
  logic          out_fatal;
  logic [2:0]    log_idx = '0;
  logic [AW-1:0] log_addr;
  logic          log_fatal;
  logic [3:0]    log_count;
  logic          log_overflow;
  logic          log_clear = 1'b0;
  logic [CW-1:0] alert_threshold = '0;
  logic          corr_clear = 1'b0;
  logic [CW-1:0] corr_count;
  logic          alert;

  int n_vec = 0;
  int n_bad = 0;

  // bench model state
  logic [AW-1:0] m_addr [LD];
  bit            m_fat  [LD];
  int            m_wp = 0;
  int            m_cnt = 0;
  bit            m_ovf = 0;
  int            m_corr = 0;

  always #4 clk = ~clk;

  ecc_guard #(.ADDR_W(AW), .LOG_DEPTH(LD), .CNT_W(CW)) u_ecc_guard (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_chk(wr_chk),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_code(rd_code),
    .out_valid(out_valid), .out_data(out_data), .out_corrected(out_corrected),
    .out_fatal(out_fatal), .log_idx(log_idx), .log_addr(log_addr),
    .log_fatal(log_fatal), .log_count(log_count), .log_overflow(log_overflow),
    .log_clear(log_clear), .alert_threshold(alert_threshold),
    .corr_clear(corr_clear), .corr_count(corr_count), .alert(alert)
  );

  // Build a Hamming word position by position, then fold parities
  function automatic logic [7:0] bench_chk(input logic [63:0] d);
    logic [127:0] slot;
    logic [7:0]   c;
    int k;
    slot = '0;
    c = '0;
    k = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        slot[p] = d[k];
        k++;
      end
    end
    for (int p = 1; p < 72; p++)
      for (int j = 0; j < 7; j++)
        if (((p >> j) & 1) == 1) c[j] = c[j] ^ slot[p];
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // kind: 0 clean, 1 one data bit, 2 one check bit, 3 two bits
  task automatic do_read(input logic [AW-1:0] a, input logic [63:0] d,
                         input int kind, input int b1, input int b2, input bit clr_cnt);
    logic [71:0] code;
    logic [63:0] expd;
    bit ec, ef, ev;
    string tag;
    code = {bench_chk(d), d};
    if (kind != 0) code[b1] = ~code[b1];
    if (kind == 3) code[b2] = ~code[b2];
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_code = code; corr_clear = clr_cnt;
    @(negedge clk);
    rd_valid = 1'b0; corr_clear = 1'b0;
    ec = (kind == 1 || kind == 2);
    ef = (kind == 3);
    ev = ec || ef;
    expd = ef ? code[63:0] : d;
    case (kind)
      0: tag = "R2";
      1: tag = "R3";
      2: tag = "R4";
      default: tag = "R5";
    endcase
    if (ev) begin
      m_addr[m_wp] = a;
      m_fat[m_wp] = ef;
      m_wp = (m_wp + 1) % LD;
      if (m_cnt == LD) m_ovf = 1'b1;
      else m_cnt++;
    end
    if (clr_cnt) m_corr = 0;
    else if (ec && m_corr != 15) m_corr++;
    check(out_valid == 1'b1, "R2", "out_valid", 64'(out_valid), 64'd1);
    check(out_data == expd, tag, "out_data", out_data, expd);
    check(out_corrected == ec, tag, "out_corrected", 64'(out_corrected), 64'(ec));
    check(out_fatal == ef, tag, "out_fatal", 64'(out_fatal), 64'(ef));
    check(int'(log_count) == m_cnt, "R7", "log_count", 64'(log_count), 64'(m_cnt));
    check(log_overflow == m_ovf, "R7", "log_overflow", 64'(log_overflow), 64'(m_ovf));
    check(int'(corr_count) == m_corr, clr_cnt ? "R10" : "R8", "corr_count",
          64'(corr_count), 64'(m_corr));
    check(alert == (alert_threshold != 0 && m_corr >= int'(alert_threshold)), "R9",
          "alert", 64'(alert), 64'(alert_threshold != 0 && m_corr >= int'(alert_threshold)));
    if (ev) begin
      log_idx = 3'd0;
      #1;
      check(log_addr == a, "R6", "log_addr newest", 64'(log_addr), 64'(a));
      check(log_fatal == ef, "R6", "log_fatal newest", 64'(log_fatal), 64'(ef));
    end
  endtask

  task automatic check_log_walk();
    for (int i = 0; i < LD; i++) begin
      log_idx = 3'(i);
      #1;
      if (i < m_cnt) begin
        int s;
        s = (m_wp - 1 - i + 2 * LD) % LD;
        check(log_addr == m_addr[s], "R6", "log_addr walk", 64'(log_addr), 64'(m_addr[s]));
        check(log_fatal == m_fat[s], "R6", "log_fatal walk", 64'(log_fatal), 64'(m_fat[s]));
      end else begin
        check(log_addr == '0 && !log_fatal, "R7", "empty slot", 64'(log_addr), 64'd0);
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=done", n_vec);
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20141015);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!out_valid && !out_corrected && !out_fatal, "R11", "out flags", 64'(out_valid), 64'd0);
    check(log_count == '0 && !log_overflow, "R11", "log empty", 64'(log_count), 64'd0);
    check(corr_count == '0 && !alert, "R11", "counter", 64'(corr_count), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 write path
    for (int i = 0; i < 40; i++) begin
      logic [63:0] d;
      if (i == 0) d = '0;
      else if (i == 1) d = '1;
      else if (i < 10) d = 64'd1 << (i * 7);
      else d = {$urandom, $urandom};
      wr_data = d;
      #1;
      check(wr_chk == bench_chk(d), "R1", "wr_chk", 64'(wr_chk), 64'(bench_chk(d)));
    end

    // directed corner cases, threshold 3
    alert_threshold = 4'd3;
    do_read(16'h0010, 64'h0123_4567_89AB_CDEF, 0, 0, 0, 0);
    do_read(16'h0020, 64'hFFFF_FFFF_0000_0000, 1, 0, 0, 0);
    do_read(16'h0030, 64'hA5A5_5A5A_A5A5_5A5A, 1, 63, 0, 0);
    do_read(16'h0040, 64'h0, 2, 64, 0, 0);
    do_read(16'h0050, 64'h1, 2, 71, 0, 0);
    do_read(16'h0060, 64'hDEAD_BEEF_CAFE_F00D, 3, 0, 71, 0);
    do_read(16'h0070, 64'h5555_5555_5555_5555, 3, 5, 6, 0);
    do_read(16'h0080, 64'h0F0F_0F0F_0F0F_0F0F, 2, 70, 0, 0);
    do_read(16'h0090, 64'h1234, 1, 31, 0, 0);
    do_read(16'h00A0, 64'h9876, 3, 64, 65, 0);
    check_log_walk();

    // R7 log clear
    @(negedge clk);
    log_clear = 1'b1;
    @(negedge clk);
    log_clear = 1'b0;
    m_cnt = 0; m_wp = 0; m_ovf = 0;
    check(log_count == '0 && !log_overflow, "R7", "after clear", 64'(log_count), 64'd0);
    check_log_walk();

    // R10 clear wins over same-cycle repair
    do_read(16'h00B0, 64'h77, 1, 9, 0, 1);
    // R9 threshold zero disables alert
    alert_threshold = 4'd0;
    for (int i = 0; i < 5; i++) do_read(16'(i), 64'(i * 3), 1, i, 0, 0);
    // R8 saturation
    alert_threshold = 4'd15;
    for (int i = 0; i < 14; i++) do_read(16'(100 + i), 64'(i), 2, 64 + (i % 8), 0, 0);

    // random mix
    corr_clear = 1'b1;
    @(negedge clk);
    corr_clear = 1'b0;
    m_corr = 0;
    alert_threshold = 4'd6;
    for (int i = 0; i < 400; i++) begin
      int k, b1, b2;
      k = $urandom % 4;
      b1 = (k == 1) ? int'($urandom % 64) : (k == 2) ? 64 + int'($urandom % 8) : int'($urandom % 72);
      b2 = (b1 + 1 + int'($urandom % 71)) % 72;
      do_read(16'($urandom), {$urandom, $urandom}, k, b1, b2, ($urandom % 50) == 0);
      if ((i % 97) == 0) check_log_walk();
    end
    check_log_walk();
    finish_run();
  end
endmodule